// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Host-Supplied Parity

This block turns one word handed over by a host into an asynchronous character on a single output line. The host strobes `load` with a 7- or 8-bit payload and a parity value of its own choosing. A one-deep holding register keeps that word until the shifter is free. The shifter then sends a start bit, the payload least significant bit first, the host's parity bit when parity is switched on, and a stop bit. Bit cells are measured in baud ticks: each cell lasts sixteen ticks of an external strobe that runs at sixteen times the bit rate. Clock cycles without a tick do not advance the cell.

The line can be driven in two ways. In plain mode each cell holds the bit level and the line rests high. In infrared mode the line rests low: a zero bit is a short high pulse at the start of its cell, and a one bit gives no pulse. A `shutdown` input forces the line to its resting level in the same cycle. On the next edge it drops the character in flight and empties the holding register.

The controller has five states. IDLE waits for a full holding register. IDLE→START moves the held word into the shifter. START→DATA follows the end of the start cell. DATA→DATA steps to the next payload bit. DATA→PARITY happens after the last payload bit when parity is on, and DATA→STOP when it is off. PARITY→STOP follows the parity cell. STOP→IDLE follows the stop cell. From any state, shutdown forces a move to IDLE.

Top module: `hptx_top`

## Requirements
- R1: Every bit cell lasts exactly 16 baud ticks. A clock cycle with `baud_tick` low never advances the cell or the state.
- R2: In plain mode (`cfg_irda`=0) the line rests high. A character is sent as a start bit of 0, then the payload with bit 0 first, then the optional parity cell, then a stop bit of 1.
- R3: With `cfg_len7`=1 the payload is `load_data[6:0]` (7 cells) and `load_data[7]` is never sent. With `cfg_len7`=0 all 8 bits are sent.
- R4: With `cfg_par_en`=1 one extra cell carrying `load_par` exactly as supplied is sent between the payload and the stop bit, whatever the payload. With `cfg_par_en`=0 no such cell exists.
- R5: In infrared mode (`cfg_irda`=1) the line rests low. A 0 cell is driven high for its first 3 ticks and low for the rest. A 1 cell stays low for the whole cell.
- R6: A `load` while `tx_empty`=1 captures the word, and `tx_empty` reads 0 after that edge. If the shifter is idle, the next edge moves the word into it: `tx_busy` goes to 1, `tx_empty` returns to 1, and the start cell begins.
- R7: A `load` while `tx_empty`=0 is ignored. The held word is unchanged and is the one sent next.
- R8: A word loaded during a character is sent starting one clock after the stop cell of that character ends.
- R9: While `shutdown`=1 the line is at its resting level in the same cycle. On the next edge the block is idle with `tx_empty`=1. Loads are ignored while `shutdown` is asserted, and nothing is sent after release until a new load.
- R10: After reset `tx_busy`=0, `tx_empty`=1 and the line is at the resting level of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| shutdown | input | 1 | Abort and hold idle while 1 |
| cfg_len7 | input | 1 | 1: 7-bit payload, 0: 8-bit payload |
| cfg_par_en | input | 1 | 1: send host parity cell |
| cfg_irda | input | 1 | 1: infrared pulse encoding |
| load | input | 1 | Write strobe for the holding register |
| load_data | input | DATA_W | Payload to send |
| load_par | input | 1 | Parity value to send |
| tx_empty | output | 1 | Holding register free |
| tx_busy | output | 1 | A character is being shifted |
| tx_line | output | 1 | Serial output |

## Verification
The bench builds the block with its default values: an 8-bit maximum payload, a 7-bit short payload, 16 ticks per cell and a 3-tick pulse. At these values every combination of word length, parity switch and line encoding can be swept, with a set of payloads in each, and every tick of every cell is compared against a frame rebuilt arithmetically in the bench. A slower tick rate confirms that cells are counted in ticks and not in clocks. Directed sequences cover the holding register being refilled and overrun, and shutdown in both line modes.

// File: rtl/hptx_pkg.sv
package hptx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;
endpackage

// File: rtl/hptx_hold.sv
module hptx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_par,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] word,
    output logic              par
);
    logic              full_q;
    logic [DATA_W-1:0] word_q;
    logic              par_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            word_q <= '0;
            par_q  <= 1'b0;
        end else if (flush) begin
            full_q <= 1'b0;
        end else if (take) begin
            full_q <= 1'b0;
        end else if (load && !full_q) begin
            full_q <= 1'b1;
            word_q <= load_data;
            par_q  <= load_par;
        end
    end

    assign full = full_q;
    assign word = word_q;
    assign par  = par_q;

    // R7: a load on a full register leaves it untouched
    assert_full_ignores_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && load && !take && !flush) |=> (full_q && word_q == $past(word_q)));

    // R9: shutdown discards the held word
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !full_q);
endmodule

// File: rtl/hptx_cellenc.sv
module hptx_cellenc #(
    parameter int CNT_W       = 4,
    parameter int PULSE_TICKS = 3
) (
    input  logic             active,
    input  logic             force_idle,
    input  logic             irda,
    input  logic             bit_val,
    input  logic [CNT_W-1:0] tick_cnt,
    output logic             line
);
    localparam logic [CNT_W-1:0] PULSE_LIM = CNT_W'(PULSE_TICKS);

    always_comb begin
        if (force_idle || !active) begin
            line = !irda;
        end else if (irda) begin
            line = !bit_val && (tick_cnt < PULSE_LIM);
        end else begin
            line = bit_val;
        end
    end
endmodule

// File: rtl/hptx_top.sv
module hptx_top
    import hptx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SHORT_W       = 7,
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              shutdown,
    input  logic              cfg_len7,
    input  logic              cfg_par_en,
    input  logic              cfg_irda,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_par,
    output logic              tx_empty,
    output logic              tx_busy,
    output logic              tx_line
);
    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_TICK  = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_W - 1);

    tx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] char_q;
    logic              par_q;
    logic              take;
    logic              cell_end;
    logic [IDX_W-1:0]  last_idx;
    logic              hold_full;
    logic [DATA_W-1:0] hold_word;
    logic              hold_par;
    logic              cur_bit;
    logic              active;

    hptx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (shutdown),
        .load      (load),
        .load_data (load_data),
        .load_par  (load_par),
        .take      (take),
        .full      (hold_full),
        .word      (hold_word),
        .par       (hold_par)
    );

    assign cell_end = baud_tick && (cnt_q == LAST_TICK);
    assign last_idx = cfg_len7 ? LAST_SHORT : LAST_LONG;

    // next-state logic
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_full) begin
                    state_d = ST_START;
                    take    = 1'b1;
                end
            end
            ST_START:  if (cell_end) state_d = ST_DATA;
            ST_DATA: begin
                if (cell_end && idx_q == last_idx) begin
                    state_d = cfg_par_en ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: if (cell_end) state_d = ST_STOP;
            ST_STOP:   if (cell_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (shutdown) begin
            state_d = ST_IDLE;
            take    = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // cell counter, bit index and shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            char_q <= '0;
            par_q  <= 1'b0;
        end else begin
            if (shutdown || state_q == ST_IDLE) begin
                cnt_q <= '0;
                idx_q <= '0;
            end else if (baud_tick) begin
                cnt_q <= cell_end ? '0 : cnt_q + 1'b1;
                if (cell_end && state_q == ST_DATA) idx_q <= idx_q + 1'b1;
            end
            if (take) begin
                char_q <= hold_word;
                par_q  <= hold_par;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_START:  cur_bit = 1'b0;
            ST_DATA:   cur_bit = char_q[idx_q];
            ST_PARITY: cur_bit = par_q;
            default:   cur_bit = 1'b1;
        endcase
        active   = (state_q != ST_IDLE);
        tx_busy  = active;
        tx_empty = !hold_full;
    end

    hptx_cellenc #(.CNT_W(CNT_W), .PULSE_TICKS(PULSE_TICKS)) u_enc (
        .active     (active),
        .force_idle (shutdown),
        .irda       (cfg_irda),
        .bit_val    (cur_bit),
        .tick_cnt   (cnt_q),
        .line       (tx_line)
    );

    // R1: without a tick the state holds
    assert_cell_waits_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !baud_tick && !shutdown) |=> (state_q == $past(state_q)));

    // R2: the stop cell is high in plain mode
    assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !cfg_irda && !shutdown) |-> tx_line);

    // R3: payload index never passes the configured last bit
    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (idx_q <= last_idx));

    // R5 (and R2): resting level follows the line mode
    assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !shutdown) |-> (tx_line == !cfg_irda));

    // R6: a held word is taken on the next edge when idle
    assert_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && hold_full && !shutdown) |=> (state_q == ST_START && !hold_full));

    // R9: shutdown forces the resting level at once and idles the block
    assert_abort_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (tx_line == !cfg_irda));
    assert_abort_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (state_q == ST_IDLE));
endmodule

// File: tb/hptx_top_bench.sv
`timescale 1ns/1ps
module hptx_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       shutdown = 1'b0;
    logic       cfg_len7 = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_irda = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_data = '0;
    logic       load_par = 1'b0;
    logic       tx_empty, tx_busy, tx_line;

    int nchk = 0;
    int nerr = 0;
    int tick_div = 1;
    int tick_ph = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (tick_ph >= tick_div - 1) begin
            baud_tick <= 1'b1;
            tick_ph = 0;
        end else begin
            baud_tick <= 1'b0;
            tick_ph++;
        end
    end

    hptx_top u_hptx_top (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .shutdown(shutdown),
        .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_irda(cfg_irda),
        .load(load), .load_data(load_data), .load_par(load_par),
        .tx_empty(tx_empty), .tx_busy(tx_busy), .tx_line(tx_line)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // samples every tick of a frame, starting just after the start edge
    task automatic expect_frame(input logic [7:0] d, input logic p);
        logic [11:0] bits;
        int n, t, bad, busybad, bad_t, c, k;
        logic expv, bad_a, bad_e;
        bits = '0; n = 0;
        bits[n] = 1'b0; n++;
        for (int i = 0; i < (cfg_len7 ? 7 : 8); i++) begin bits[n] = d[i]; n++; end
        if (cfg_par_en) begin bits[n] = p; n++; end
        bits[n] = 1'b1; n++;
        t = 0; bad = 0; busybad = 0; bad_t = 0; bad_a = 0; bad_e = 0;
        while (t < n * 16) begin
            @(negedge clk);
            c = t / 16; k = t % 16;
            expv = cfg_irda ? (!bits[c] && k < 3) : bits[c];
            if (tx_line !== expv) begin
                if (bad == 0) begin bad_t = t; bad_a = tx_line; bad_e = expv; end
                bad++;
            end
            if (tx_busy !== 1'b1) busybad++;
            @(posedge clk);
            if (baud_tick) t++;
        end
        if (bad != 0) $display("  frame d=%0h p=%0b len7=%0b par=%0b irda=%0b first bad tick %0d",
                               d, p, cfg_len7, cfg_par_en, cfg_irda, bad_t);
        check(bad == 0, "R1 R2 R3 R4 R5 frame line", int'(bad_a), int'(bad_e));
        check(busybad == 0, "R6 busy during frame", busybad, 0);
    endtask

    task automatic put_word(input logic [7:0] d, input logic p);
        @(negedge clk);
        load = 1'b1; load_data = d; load_par = p;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic p);
        put_word(d, p);
        check(tx_empty === 1'b0, "R6 empty low after load", int'(tx_empty), 0);
        check(tx_busy === 1'b0, "R6 not busy before handoff", int'(tx_busy), 0);
        @(posedge clk);
        expect_frame(d, p);
        @(negedge clk);
        check(tx_busy === 1'b0 && tx_empty === 1'b1, "R6 idle after frame", int'(tx_busy), 0);
        check(tx_line === !cfg_irda, "R2 R5 resting level", int'(tx_line), int'(!cfg_irda));
    endtask

    initial begin
        logic [7:0] d;
        logic p;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(tx_busy === 1'b0, "R10 busy in reset", int'(tx_busy), 0);
        check(tx_empty === 1'b1, "R10 empty in reset", int'(tx_empty), 1);
        check(tx_line === 1'b1, "R10 plain resting level", int'(tx_line), 1);
        cfg_irda = 1'b1;
        #1 check(tx_line === 1'b0, "R10 infrared resting level", int'(tx_line), 0);
        cfg_irda = 1'b0;
        rst_n = 1'b1;

        // sweep of word length, parity switch, line mode and payloads
        for (int m = 0; m < 8; m++) begin
            cfg_len7 = m[0]; cfg_par_en = m[1]; cfg_irda = m[2];
            for (int i = 0; i < 8; i++) begin
                if (i == 0) d = 8'h00;
                else if (i == 1) d = 8'hFF;
                else d = 8'((i * 91 + 19) ^ (i << 5));
                p = ((i % 3) == 0);
                send(d, p);
            end
        end

        // R1: slower tick, cells still 16 ticks
        tick_div = 3;
        cfg_len7 = 1'b0; cfg_par_en = 1'b1; cfg_irda = 1'b0;
        send(8'hA6, 1'b1);
        cfg_irda = 1'b1;
        send(8'h39, 1'b0);
        tick_div = 1;

        // R7 R8: refill while shifting, overrun ignored
        cfg_len7 = 1'b0; cfg_par_en = 1'b0; cfg_irda = 1'b0;
        put_word(8'h5A, 1'b0);
        @(posedge clk);
        fork
            expect_frame(8'h5A, 1'b0);
            begin
                repeat (5) @(negedge clk);
                load = 1'b1; load_data = 8'hC3; load_par = 1'b0;
                @(negedge clk);
                check(tx_empty === 1'b0, "R6 refill captured", int'(tx_empty), 0);
                load_data = 8'h0F;
                @(negedge clk);
                load = 1'b0;
                check(tx_empty === 1'b0, "R7 still full after overrun", int'(tx_empty), 0);
            end
        join
        @(posedge clk);
        expect_frame(8'hC3, 1'b0);
        @(negedge clk);
        check(tx_busy === 1'b0 && tx_empty === 1'b1, "R7 R8 nothing after held word", int'(tx_busy), 0);
        repeat (20) @(negedge clk);
        check(tx_busy === 1'b0 && tx_line === 1'b1, "R7 overrun word not sent", int'(tx_busy), 0);

        // R9: shutdown in plain mode, payload all zero
        put_word(8'h00, 1'b0);
        @(posedge clk);
        repeat (40) @(negedge clk);
        check(tx_line === 1'b0 && tx_busy === 1'b1, "R9 data cell before abort", int'(tx_line), 0);
        load = 1'b1; load_data = 8'h81;
        @(negedge clk);
        load = 1'b0;
        check(tx_empty === 1'b0, "R9 refill before abort", int'(tx_empty), 0);
        shutdown = 1'b1; load = 1'b1; load_data = 8'h77;
        #1 check(tx_line === 1'b1, "R9 plain line idles at once", int'(tx_line), 1);
        @(negedge clk);
        check(tx_busy === 1'b0 && tx_empty === 1'b1, "R9 idle after abort edge", int'(tx_busy), 0);
        repeat (3) @(negedge clk);
        shutdown = 1'b0; load = 1'b0;
        begin
            int bad = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (tx_busy !== 1'b0 || tx_line !== 1'b1 || tx_empty !== 1'b1) bad++;
            end
            check(bad == 0, "R9 nothing sent after release", bad, 0);
        end

        // R9: shutdown in infrared mode during a start pulse
        cfg_irda = 1'b1;
        put_word(8'h00, 1'b0);
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        check(tx_line === 1'b1, "R5 start pulse high", int'(tx_line), 1);
        shutdown = 1'b1;
        #1 check(tx_line === 1'b0, "R9 infrared line idles at once", int'(tx_line), 0);
        @(negedge clk);
        shutdown = 1'b0;
        check(tx_busy === 1'b0, "R9 infrared abort idle", int'(tx_busy), 0);

        // recovery after shutdown
        cfg_irda = 1'b0;
        send(8'h6D, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule